// File: doc/BRIEF.md
# MII Carrier Sense and Collision Indication

This block drives the carrier-sense and collision outputs that a physical-layer transceiver presents on its media independent interface. It takes the transmit enable from the MAC, a receive-activity flag from the line receiver, and a few quasi-static configuration inputs. From these it produces both outputs combinationally, so the MAC sees a change in line state in the same cycle that it happens.

Carrier sense can be built from both directions or from receive activity alone. Full duplex always uses receive only. Collision is the coincidence of transmit and receive activity in half duplex, and it is forced low in full duplex. When the 10 Mbit/s serial interface variant is in use, the collision pin instead reports that the jabber timer has expired. That timer and the detection of receive activity are outside this block.

Top module: `mii_crs_col`

## Requirements
- R1: In half duplex with serial mode off, col_o equals tx_en_i AND rx_active_i.
- R2: With full_duplex_i high, col_o is 0 for every value of the other inputs, including serial mode with jabber set.
- R3: In half duplex with serial_10m_i high, col_o equals jabber_expired_i, and tx_en_i and rx_active_i have no effect on it.
- R4: With serial_10m_i low, jabber_expired_i has no effect on col_o or crs_o.
- R5: In half duplex with crs_rx_only_i low, crs_o equals tx_en_i OR rx_active_i.
- R6: In half duplex with serial mode off, crs_o is high whenever col_o is high, so carrier sense covers the whole collision.
- R7: In half duplex with crs_rx_only_i high, crs_o equals rx_active_i.
- R8: With full_duplex_i high, crs_o equals rx_active_i whatever crs_rx_only_i is.
- R9: serial_10m_i has no effect on crs_o.
- R10: Both outputs are combinational and settle within the cycle in which an input changes, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_en_i | input | 1 | Transmit enable from the MAC |
| rx_active_i | input | 1 | Receive activity detected on the line |
| full_duplex_i | input | 1 | 1 = full duplex, 0 = half duplex |
| crs_rx_only_i | input | 1 | 1 = carrier sense from receive only, 0 = from either direction |
| serial_10m_i | input | 1 | 1 = serial 10 Mbit/s interface selected |
| jabber_expired_i | input | 1 | Jabber timer has expired |
| crs_o | output | 1 | Carrier sense to the MAC |
| col_o | output | 1 | Collision, or jabber indication in serial mode |

## Verification
The checker holds the output relations of every mode continuously: the collision forms in half duplex, the forced-low collision in full duplex, each carrier-sense source, and carrier sense covering any collision. Because the checks are immediate, they also see each input change. What only the bench's sweep shows is that inputs marked as ignored really leave the outputs unchanged when they are toggled. The sweep covers all 64 input combinations and samples within the same cycle as each change, which shows that no register sits on the path.

// File: rtl/mii_crs_col_pkg.sv
package mii_crs_col_pkg;

    // Source selected for the collision output.
    typedef enum logic [1:0] {
        COL_SRC_NONE   = 2'd0,
        COL_SRC_COLL   = 2'd1,
        COL_SRC_JABBER = 2'd2
    } col_src_e;

    // Source selected for the carrier-sense output.
    typedef enum logic {
        CRS_SRC_BOTH = 1'b0,
        CRS_SRC_RX   = 1'b1
    } crs_src_e;

    typedef struct packed {
        col_src_e col_src;
        crs_src_e crs_src;
    } sense_cfg_t;

endpackage

// File: rtl/mii_sense_cfg.sv
module mii_sense_cfg
    import mii_crs_col_pkg::*;
(
    input  logic       full_duplex_i,
    input  logic       crs_rx_only_i,
    input  logic       serial_10m_i,
    output sense_cfg_t cfg_o
);
    sense_cfg_t cfg_d;

    always_comb begin
        cfg_d = '{col_src: COL_SRC_COLL, crs_src: CRS_SRC_BOTH};
        // Full duplex forces collision low ahead of the serial jabber mode.
        if (full_duplex_i)
            cfg_d.col_src = COL_SRC_NONE;
        else if (serial_10m_i)
            cfg_d.col_src = COL_SRC_JABBER;
        if (full_duplex_i || crs_rx_only_i)
            cfg_d.crs_src = CRS_SRC_RX;
    end

    assign cfg_o = cfg_d;
endmodule

// File: rtl/mii_col_gen.sv
module mii_col_gen
    import mii_crs_col_pkg::*;
(
    input  col_src_e src_i,
    input  logic     tx_en_i,
    input  logic     rx_active_i,
    input  logic     jabber_expired_i,
    output logic     col_o
);
    logic col_d;

    always_comb begin
        unique case (src_i)
            COL_SRC_COLL:   col_d = tx_en_i & rx_active_i;
            COL_SRC_JABBER: col_d = jabber_expired_i;
            default:        col_d = 1'b0;
        endcase
    end

    assign col_o = col_d;
endmodule

// File: rtl/mii_crs_gen.sv
module mii_crs_gen
    import mii_crs_col_pkg::*;
(
    input  crs_src_e src_i,
    input  logic     tx_en_i,
    input  logic     rx_active_i,
    output logic     crs_o
);
    logic crs_d;

    always_comb begin
        if (src_i == CRS_SRC_RX)
            crs_d = rx_active_i;
        else
            crs_d = tx_en_i | rx_active_i;
    end

    assign crs_o = crs_d;
endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
    import mii_crs_col_pkg::*;
(
    input  logic tx_en_i,
    input  logic rx_active_i,
    input  logic full_duplex_i,
    input  logic crs_rx_only_i,
    input  logic serial_10m_i,
    input  logic jabber_expired_i,
    output logic crs_o,
    output logic col_o
);
    sense_cfg_t cfg;

    mii_sense_cfg cfg_i (
        .full_duplex_i (full_duplex_i),
        .crs_rx_only_i (crs_rx_only_i),
        .serial_10m_i  (serial_10m_i),
        .cfg_o         (cfg)
    );

    mii_col_gen col_i (
        .src_i            (cfg.col_src),
        .tx_en_i          (tx_en_i),
        .rx_active_i      (rx_active_i),
        .jabber_expired_i (jabber_expired_i),
        .col_o            (col_o)
    );

    mii_crs_gen crs_i (
        .src_i       (cfg.crs_src),
        .tx_en_i     (tx_en_i),
        .rx_active_i (rx_active_i),
        .crs_o       (crs_o)
    );
endmodule

// File: rtl/mii_crs_col_chk.sv
module mii_crs_col_chk (
    input logic tx_en_i,
    input logic rx_active_i,
    input logic full_duplex_i,
    input logic crs_rx_only_i,
    input logic serial_10m_i,
    input logic jabber_expired_i,
    input logic crs_o,
    input logic col_o
);
    // Block has no clock; port relations are checked on every input change.
    always_comb begin
        if (!full_duplex_i && !serial_10m_i)
            assert_col_coincide_R1: assert (col_o == (tx_en_i && rx_active_i))
                else $error("R1 collision mismatch");
        if (full_duplex_i)
            assert_col_fdx_low_R2: assert (!col_o)
                else $error("R2 collision in full duplex");
        if (!full_duplex_i && serial_10m_i)
            assert_col_jabber_R3: assert (col_o == jabber_expired_i)
                else $error("R3 jabber mismatch");
        if (!full_duplex_i && !crs_rx_only_i)
            assert_crs_either_R5: assert (crs_o == (tx_en_i || rx_active_i))
                else $error("R5 carrier mismatch");
        if (!full_duplex_i && !serial_10m_i && col_o)
            assert_crs_covers_col_R6: assert (crs_o)
                else $error("R6 carrier dropped in collision");
        if (full_duplex_i || crs_rx_only_i)
            assert_crs_rx_only_R7: assert (crs_o == rx_active_i)
                else $error("R7/R8 carrier mismatch");
    end
endmodule

bind mii_crs_col mii_crs_col_chk chk_i (
    .tx_en_i          (tx_en_i),
    .rx_active_i      (rx_active_i),
    .full_duplex_i    (full_duplex_i),
    .crs_rx_only_i    (crs_rx_only_i),
    .serial_10m_i     (serial_10m_i),
    .jabber_expired_i (jabber_expired_i),
    .crs_o            (crs_o),
    .col_o            (col_o)
);

// File: tb/mii_crs_col_tb.sv
module mii_crs_col_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en, rx_act, fdx, rx_only, ser, jab;
    logic crs, col;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mii_crs_col dut_i (
        .tx_en_i          (tx_en),
        .rx_active_i      (rx_act),
        .full_duplex_i    (fdx),
        .crs_rx_only_i    (rx_only),
        .serial_10m_i     (ser),
        .jabber_expired_i (jab),
        .crs_o            (crs),
        .col_o            (col)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b tx=%b rx=%b fdx=%b sel=%b ser=%b jab=%b",
                     req, act, exp, tx_en, rx_act, fdx, rx_only, ser, jab);
        end
    endtask

    initial begin
        {tx_en, rx_act, fdx, rx_only, ser, jab} = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1 idle col", col, 1'b0);
        check("R5 idle crs", crs, 1'b0);
        // Sweep all 64 combinations; inputs change mid-cycle and are
        // sampled before the next rising edge (R10).
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            {tx_en, rx_act, fdx, rx_only, ser, jab} = 6'(v);
            #3;
            begin
                logic ec, es;
                string cr, sr;
                if (fdx) begin ec = 1'b0; cr = "R2"; end
                else if (ser) begin ec = jab; cr = "R3"; end
                else begin ec = tx_en & rx_act; cr = (jab ? "R4" : "R1"); end
                if (fdx) begin es = rx_act; sr = "R8"; end
                else if (rx_only) begin es = rx_act; sr = "R7"; end
                else begin es = tx_en | rx_act; sr = "R5"; end
                if (ser) sr = {sr, "/R9"};
                check({cr, " col R10"}, col, ec);
                check({sr, " crs R10"}, crs, es);
                if (!fdx && !ser && tx_en && rx_act)
                    check("R6 crs during collision", crs, 1'b1);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule